// File: doc/BRIEF.md
# Address-Masked GPIO Bank with Pin Interrupts

This block is an eight-pin general-purpose I/O bank on a byte-wide register bus. Each pin can be an input or a driven output. Data accesses go through a window at the bottom of the address space, where address bits [9:2] act as a per-pin mask. Software can therefore read or update any subset of pins in one access, with no read-modify-write.

Every pin has its own interrupt detector. It can trigger on a high or low level, on a rising or falling edge, or on both edges. Edge events are latched and cleared by a write-one-to-clear register. Level conditions track the synchronised pin directly. Raw status, enabled (masked) status and a single combined interrupt line are provided. Inputs pass through a two-flop synchroniser before any detection or data read.

Top module: `mgpio`

## Requirements
- R1: After reset every register reads 0, `pin_oe_o` is 0, `pin_o` is 0 and `irq_o` is 0.
- R2: A read in the data window returns, for each pin whose mask bit (address bit 2+pin) is set, the driven value if the pin is an output, or the synchronised input if it is an input. Unmasked pins read 0. The data window is every word-aligned address with bits [11:10] equal to 0.
- R3: A data-window write changes the driven value only of output pins whose mask bit (address bit 2+pin) is set. All other driven values keep their state.
- R4: Direction register (0x400): bit 1 makes a pin an output and sets its `pin_oe_o` bit. A data write to a pin that is an input leaves its driven value unchanged, including after the pin is later switched to output.
- R5: With the sense bit (0x404) at 1, the pin's raw status is level-triggered. It follows the synchronised input when the event bit (0x40C) is 1 (active high), and its inverse when the event bit is 0. A clear write does not affect it.
- R6: With the sense bit at 0 and the both-edges bit (0x408) at 0, an event bit of 1 latches raw status on a rising edge and 0 latches it on a falling edge. The status stays set after the pin returns.
- R7: With the sense bit at 0 and the both-edges bit at 1, either edge latches raw status, whatever the event bit holds.
- R8: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge status. Bits written 0 leave the status unchanged.
- R9: Masked status (0x418) is raw status (0x414) ANDed with the enable register (0x410). `irq_o` is high exactly when any masked status bit is set.
- R10: The configuration registers read back what was written. Writes to the raw and masked status registers are ignored. The clear register and all unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address while selected |
| pin_i | input | 8 | Asynchronous pin inputs |
| pin_o | output | 8 | Driven pin values |
| pin_oe_o | output | 8 | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The edge-latch and clear assertions assume that `pin_i` changes at most once per synchroniser window, so each transition is seen as a single edge. The bench drives pins only at falling clock edges and holds each level for four cycles. The write-mask and input-hold assertions assume each bus access lasts one cycle. The bench's bus tasks raise `bus_sel_i` for exactly one rising edge and keep address and data stable around it. Interrupt cases are set up with pins held low and edge status cleared, so no stale event can carry into the next mode.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_EVENT = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MIS   = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH,
    SEL_EVENT, SEL_IEN, SEL_RAW, SEL_MIS, SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);
  // stage STAGES-1 is the synchronised value, stage STAGES its one-cycle delay
  logic [NPINS-1:0] stg_q [STAGES+1];

  for (genvar k = 0; k <= STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[k] <= '0;
        else         stg_q[k] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[k] <= '0;
        else         stg_q[k] <= stg_q[k-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/mgpio_detect.sv
module mgpio_detect #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] raw_o
);
  logic [NPINS-1:0] edge_q;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] latch_set;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = sync_i[g] & ~prev_i[g];
    assign fall = ~sync_i[g] & prev_i[g];
    // both-edges overrides the polarity select
    assign hit[g] = both_i[g] ? (rise | fall) : (event_i[g] ? rise : fall);
    assign latch_set[g] = hit[g] & ~sense_i[g];

    // a new edge wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           edge_q[g] <= 1'b0;
      else if (latch_set[g]) edge_q[g] <= 1'b1;
      else if (clr_i[g])     edge_q[g] <= 1'b0;
    end

    assign raw_o[g] = sense_i[g] ? ~(sync_i[g] ^ event_i[g]) : edge_q[g];
  end

  a_r6_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_set != '0) |=> ((edge_q & $past(latch_set)) == $past(latch_set)));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((edge_q & $past(clr_i & ~latch_set)) == '0));
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [NPINS-1:0]  raw_i,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  sense_o,
  output logic [NPINS-1:0]  both_o,
  output logic [NPINS-1:0]  event_o,
  output logic [NPINS-1:0]  ien_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]  out_o
);
  localparam int unsigned MASK_MSB = NPINS + 1;

  logic [NPINS-1:0] pin_mask;
  logic             in_window;
  logic             wr;
  reg_sel_e         sel;

  logic [NPINS-1:0] dir_q, sense_q, both_q, event_q, ien_q, out_q;

  assign pin_mask  = bus_addr_i[MASK_MSB:2];
  assign in_window = (bus_addr_i[ADDR_W-1:MASK_MSB+1] == '0) && (bus_addr_i[1:0] == 2'b00);
  assign wr        = bus_sel_i & bus_we_i;

  always_comb begin
    sel = SEL_NONE;
    if (in_window) sel = SEL_DATA;
    else begin
      case (bus_addr_i)
        OFS_DIR:   sel = SEL_DIR;
        OFS_SENSE: sel = SEL_SENSE;
        OFS_BOTH:  sel = SEL_BOTH;
        OFS_EVENT: sel = SEL_EVENT;
        OFS_IEN:   sel = SEL_IEN;
        OFS_RAW:   sel = SEL_RAW;
        OFS_MIS:   sel = SEL_MIS;
        OFS_CLR:   sel = SEL_CLR;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ien_q   <= '0;
      out_q   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DATA:  out_q   <= (out_q & ~(pin_mask & dir_q)) | (bus_wdata_i & pin_mask & dir_q);
        SEL_DIR:   dir_q   <= bus_wdata_i;
        SEL_SENSE: sense_q <= bus_wdata_i;
        SEL_BOTH:  both_q  <= bus_wdata_i;
        SEL_EVENT: event_q <= bus_wdata_i;
        SEL_IEN:   ien_q   <= bus_wdata_i;
        default:   ;
      endcase
    end
  end

  assign clr_o = (wr && sel == SEL_CLR) ? bus_wdata_i : '0;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (sel)
        SEL_DATA:  bus_rdata_o = ((dir_q & out_q) | (~dir_q & sync_i)) & pin_mask;
        SEL_DIR:   bus_rdata_o = dir_q;
        SEL_SENSE: bus_rdata_o = sense_q;
        SEL_BOTH:  bus_rdata_o = both_q;
        SEL_EVENT: bus_rdata_o = event_q;
        SEL_IEN:   bus_rdata_o = ien_q;
        SEL_RAW:   bus_rdata_o = raw_i;
        SEL_MIS:   bus_rdata_o = raw_i & ien_q;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign dir_o   = dir_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign event_o = event_q;
  assign ien_o   = ien_q;
  assign out_o   = out_q;

  a_r3_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_DATA) |=> (((out_q ^ $past(out_q)) & ~$past(pin_mask)) == '0));

  a_r4_input_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

  a_r10_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(dir_q) && $stable(ien_q) && $stable(sense_q)));
endmodule

// File: rtl/mgpio.sv
module mgpio
  import mgpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sync, prev, raw;
  logic [NPINS-1:0] dir, sense, both, evt, ien, clr, outv;

  mgpio_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .pin_i, .sync_o(sync), .prev_o(prev)
  );

  mgpio_detect #(.NPINS(NPINS)) u_detect (
    .clk_i, .rst_ni, .sync_i(sync), .prev_i(prev), .sense_i(sense),
    .both_i(both), .event_i(evt), .clr_i(clr), .raw_o(raw)
  );

  mgpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .sync_i(sync), .raw_i(raw), .dir_o(dir), .sense_o(sense),
    .both_o(both), .event_o(evt), .ien_o(ien), .clr_o(clr), .out_o(outv)
  );

  assign pin_o    = outv;
  assign pin_oe_o = dir;
  assign irq_o    = |(raw & ien);

  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien != '0));

  a_r4_oe_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i == OFS_DIR) |=> (pin_oe_o == $past(bus_wdata_i)));
endmodule

// File: tb/mgpio_tb_top.sv
module mgpio_tb_top;
  import mgpio_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [7:0]  pins = '0, pin_o, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgpio dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // mode: 0 level high, 1 level low, 2 rising, 3 falling, 4 both edges
  // phase: 0 pin low initially, 1 after rise, 2 after fall
  function automatic logic exp_raw(input int md, input int ph);
    case (md)
      0: return ph == 1;
      1: return ph != 1;
      2: return ph != 0;
      3: return ph == 2;
      default: return ph != 0;
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, model, v;
    logic [11:0] regs [8];
    regs = '{OFS_DIR, OFS_SENSE, OFS_BOTH, OFS_EVENT, OFS_IEN, OFS_RAW, OFS_MIS, OFS_CLR};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", pin_oe, 8'h00);
    check("R1 pin_o", pin_o, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      bus_rd(regs[i], d);
      check("R1 reg", d, 8'h00);
    end
    bus_rd(12'h3FC, d);
    check("R1 data", d, 8'h00);

    // R3 / R2 mask sweep with all pins outputs
    bus_wr(OFS_DIR, 8'hFF);
    check("R4 oe", pin_oe, 8'hFF);
    model = 8'h00;
    for (int m = 0; m < 256; m++) begin
      v = 8'(m * 37 + 11);
      bus_wr(12'(m << 2), v);
      model = (model & ~8'(m)) | (v & 8'(m));
      check("R3 write", pin_o, model);
      bus_rd(12'(m << 2), d);
      check("R2 read out", d, model & 8'(m));
    end

    // R2 input reads
    bus_wr(OFS_DIR, 8'h00);
    for (int p = 0; p < 6; p++) begin
      v = 8'(p * 91 + 5);
      pins = v;
      settle();
      for (int k = 0; k < 4; k++) begin
        logic [7:0] mk;
        mk = 8'(8'hFF >> (k * 2)) ^ 8'(k * 17);
        bus_rd(12'({mk, 2'b00}), d);
        check("R2 read in", d, v & mk);
      end
    end
    // R2 mixed directions
    bus_wr(OFS_DIR, 8'hF0);
    pins = 8'h3C;
    settle();
    bus_rd(12'h3FC, d);
    check("R2 mixed", d, (model & 8'hF0) | (8'h3C & 8'h0F));

    // R4 writes to inputs ignored
    bus_wr(OFS_DIR, 8'h0F);
    bus_wr(12'h3FC, 8'hFF);
    model = (model & 8'hF0) | 8'h0F;
    check("R4 input ignored", pin_o, model);
    bus_wr(OFS_DIR, 8'hFF);
    check("R4 after switch", pin_o, model);
    bus_wr(12'h3FC, 8'hFF);
    check("R4 rewrite", pin_o, 8'hFF);

    // R10 readback, read-only and unmapped
    bus_wr(OFS_DIR, 8'hA5);
    bus_rd(OFS_DIR, d);
    check("R10 dir readback", d, 8'hA5);
    bus_wr(OFS_EVENT, 8'h3C);
    bus_rd(OFS_EVENT, d);
    check("R10 event readback", d, 8'h3C);
    bus_wr(OFS_DIR, 8'h00);
    pins = 8'h00;
    settle();
    bus_wr(OFS_SENSE, 8'h00);
    bus_wr(OFS_EVENT, 8'h00);
    bus_wr(OFS_CLR, 8'hFF);
    bus_wr(OFS_RAW, 8'hFF);
    bus_rd(OFS_RAW, d);
    check("R10 raw read-only", d, 8'h00);
    bus_wr(OFS_MIS, 8'hFF);
    bus_rd(OFS_MIS, d);
    check("R10 mis read-only", d, 8'h00);
    bus_rd(12'h420, d);
    check("R10 unmapped 420", d, 8'h00);
    bus_rd(12'h800, d);
    check("R10 unmapped 800", d, 8'h00);
    bus_wr(OFS_IEN, 8'h5A);
    bus_rd(OFS_CLR, d);
    check("R10 clear reads zero", d, 8'h00);
    bus_rd(OFS_IEN, d);
    check("R10 ien readback", d, 8'h5A);
    bus_wr(OFS_IEN, 8'h00);

    // R5..R9 interrupt sweep over every pin and mode
    for (int p = 0; p < 8; p++) begin
      for (int md = 0; md < 5; md++) begin
        logic [7:0] b, e;
        b = 8'(1 << p);
        pins = 8'h00;
        settle();
        bus_wr(OFS_SENSE, (md < 2) ? b : 8'h00);
        bus_wr(OFS_BOTH, (md == 4) ? b : 8'h00);
        bus_wr(OFS_EVENT, (md == 0 || md == 2 || (md == 4 && p[0])) ? b : 8'h00);
        bus_wr(OFS_IEN, b);
        bus_wr(OFS_CLR, 8'hFF);
        settle();
        e = exp_raw(md, 0) ? b : 8'h00;
        bus_rd(OFS_RAW, d);
        check((md < 2) ? "R5 idle" : "R6 idle", d, e);

        pins = b;
        settle();
        e = exp_raw(md, 1) ? b : 8'h00;
        bus_rd(OFS_RAW, d);
        check((md < 2) ? "R5 high" : (md == 4) ? "R7 rise" : "R6 rise", d, e);
        check("R9 irq", {7'd0, irq}, {7'd0, e != 0});

        pins = 8'h00;
        settle();
        e = exp_raw(md, 2) ? b : 8'h00;
        bus_rd(OFS_RAW, d);
        check((md < 2) ? "R5 low" : (md == 4) ? "R7 fall" : "R6 fall", d, e);
        bus_rd(OFS_MIS, d);
        check("R9 mis", d, e);
        check("R9 irq", {7'd0, irq}, {7'd0, e != 0});

        bus_wr(OFS_CLR, ~b);
        bus_rd(OFS_RAW, d);
        check("R8 zero bits no effect", d, e);

        bus_wr(OFS_CLR, b);
        e = (md == 1) ? b : 8'h00;
        bus_rd(OFS_RAW, d);
        check((md < 2) ? "R5 clear ignored" : "R8 clear", d, e);

        bus_wr(OFS_IEN, 8'h00);
        bus_rd(OFS_MIS, d);
        check("R9 mis disabled", d, 8'h00);
        check("R9 irq disabled", {7'd0, irq}, 8'h00);
      end
    end

    finish_run();
  end
endmodule